// File: doc/BRIEF.md
# I2C SCL timing generator

This block produces the serial clock for an I2C master from a fast core clock. The SCL period is set by a programmable divider. The low half and the high half of the period each last half of that divider. Within every period the block raises two single-cycle strobes. The launch strobe tells the byte engine when to put the next data bit on SDA after SCL has fallen. The sample strobe tells it when to capture SDA after SCL has risen. The byte engine itself is outside this block.

The block only ever pulls SCL low or releases it, and it reads back the real level of the line. A slave can hold SCL low after the block has released it, which is clock stretching. While that happens the high phase does not start counting. If the line stays held for longer than a programmable number of SCL periods, the block declares the slave unresponsive. It then releases SCL and raises a timeout flag that stays set until the block is disabled. Programming a timeout of zero turns this check off.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, and in the cycle after `enable` is sampled low, SCL is released (`scl_drive_low`=0) and `launch_stb`, `sample_stb` and `timeout_flag` are all 0.
- R2: Let D be `divider` with bit 0 forced to 0. Without stretching, SCL is driven low for D/2 consecutive cycles and then released for D/2 cycles, and this pattern repeats.
- R3: A divider whose value with bit 0 cleared is zero (0 or 1) acts as D = 2^(DIV_W-1), which is 32768 by default.
- R4: `launch_stb` pulses exactly once per low phase, in the cycle whose index from the first low cycle (index 0) equals `fall_dly`.
- R5: `sample_stb` pulses exactly once per high phase, in the cycle whose index equals `rise_dly`. Index 0 is the first cycle of that phase in which `scl_in` reads high.
- R6: A `fall_dly` or `rise_dly` of D/2 or more is clamped, so its strobe falls on the last cycle of its phase (index D/2-1).
- R7: While SCL is released and `scl_in` reads low, the high-phase count is paused and no sample strobe is given. The high phase then lasts D/2 cycles of `scl_in` high.
- R8: If `scl_in` stays low for `tmo_cycles`×D cycles within one released phase, `timeout_flag` rises in the next cycle. While the flag is set, SCL is released, no strobes are given, and the flag holds until `enable` goes low.
- R9: With `tmo_cycles` = 0, no amount of stretching raises `timeout_flag`.
- R10: The first cycle after an idle block sees `enable` high starts a low phase, so SCL is driven low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock generator; low returns it to idle |
| divider | input | DIV_W | SCL period in core clocks; bit 0 ignored |
| fall_dly | input | DIV_W | Cycles from SCL fall to the launch strobe |
| rise_dly | input | DIV_W | Cycles from SCL seen high to the sample strobe |
| tmo_cycles | input | TMO_W | Stretch limit in SCL periods; 0 disables |
| scl_in | input | 1 | Sensed SCL level on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| launch_stb | output | 1 | Single-cycle data launch strobe |
| sample_stb | output | 1 | Single-cycle data sample strobe |
| timeout_flag | output | 1 | Sticky slave-unresponsive flag |

## Verification
Two functions can fall in the same cycle. One is a strobe; the other is the end of the phase that strobe belongs to. A delay equal to or larger than half the divider, or a divider of 2, puts the launch or sample strobe on the very cycle in which SCL changes phase. The sweep runs every delay value from 0 to D/2+1 against every divider from 2 to 13. For each cycle it compares the SCL drive and both strobes against a pattern built from the period arithmetic, so a strobe that slips into the next phase or disappears shows up as a mismatch. A second coincidence is the stretch counter wrapping on the same cycle it reaches the limit. This is judged at exactly one cycle short of the limit and at the limit itself.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int DIV_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] divider,
  input  logic [DIV_W-1:0] fall_dly,
  input  logic [DIV_W-1:0] rise_dly,
  input  logic [TMO_W-1:0] tmo_cycles,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             launch_stb,
  output logic             sample_stb,
  output logic             timeout_flag
);

  localparam logic [DIV_W-1:0] DIV_ZERO = DIV_W'(1) << (DIV_W-1);
  localparam logic [TMO_W-1:0] PER_MAX  = '1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_TMO} state_t;

  state_t           state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] st_clk;
  logic [TMO_W-1:0] st_per;

  logic [DIV_W-1:0] even_div, eff_div, half, last;
  logic [DIV_W-1:0] fall_pt, rise_pt;
  logic             phase_end, per_wrap, tmo_hit;

  assign even_div  = {divider[DIV_W-1:1], 1'b0};
  assign eff_div   = (even_div == '0) ? DIV_ZERO : even_div;
  assign half      = eff_div >> 1;
  assign last      = half - DIV_W'(1);
  assign fall_pt   = (fall_dly >= half) ? last : fall_dly;
  assign rise_pt   = (rise_dly >= half) ? last : rise_dly;
  assign phase_end = (cnt == last);
  assign per_wrap  = (st_clk == eff_div - DIV_W'(1));
  assign tmo_hit   = per_wrap && (tmo_cycles != '0) &&
                     ((st_per + TMO_W'(1)) == tmo_cycles);

  assign scl_drive_low = (state == S_LOW);
  assign launch_stb    = (state == S_LOW) && (cnt == fall_pt);
  assign sample_stb    = (state == S_HIGH) && scl_in && (cnt == rise_pt);
  assign timeout_flag  = (state == S_TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      st_clk <= '0;
      st_per <= '0;
    end else if (!enable) begin
      state  <= S_IDLE;
      cnt    <= '0;
      st_clk <= '0;
      st_per <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          state <= S_LOW;
          cnt   <= '0;
        end
        S_LOW: begin
          if (phase_end) begin
            state  <= S_HIGH;
            cnt    <= '0;
            st_clk <= '0;
            st_per <= '0;
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        S_HIGH: begin
          if (scl_in) begin
            if (phase_end) begin
              state <= S_LOW;
              cnt   <= '0;
            end else begin
              cnt <= cnt + DIV_W'(1);
            end
          end else if (per_wrap) begin
            st_clk <= '0;
            if (st_per != PER_MAX) st_per <= st_per + TMO_W'(1);
            if (tmo_hit) state <= S_TMO;
          end else begin
            st_clk <= st_clk + DIV_W'(1);
          end
        end
        default: state <= S_TMO;
      endcase
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !launch_stb && !sample_stb && !timeout_flag));

  p_launch_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> scl_drive_low);

  p_sample_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!scl_drive_low && scl_in));

  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && !scl_in && enable) |=> $stable(cnt));

  p_tmo_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> (!scl_drive_low && !launch_stb && !sample_stb));

  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && enable) |=> timeout_flag);

  p_tmo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> ($past(tmo_cycles) != '0));

  p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && enable) |=> scl_drive_low);

endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        hold = 1'b0;
  logic [15:0] divider = 16'd2;
  logic [15:0] fall_dly = '0;
  logic [15:0] rise_dly = '0;
  logic [15:0] tmo_cycles = '0;
  logic        scl_in, scl_drive_low, launch_stb, sample_stb, timeout_flag;
  int          checks = 0;
  int          errors = 0;

  assign scl_in = !scl_drive_low && !hold;
  always #5 clk = ~clk;

  i2c_scl_timer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divider(divider),
    .fall_dly(fall_dly), .rise_dly(rise_dly), .tmo_cycles(tmo_cycles),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .launch_stb(launch_stb),
    .sample_stb(sample_stb), .timeout_flag(timeout_flag));

  function automatic logic [3:0] obs();
    return {scl_drive_low, launch_stb, sample_stb, timeout_flag};
  endfunction

  task automatic chk(string req, int t, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%b expected=%b (drive,launch,sample,tmo)", req, t, act, exp);
    end
  endtask

  function automatic int half_of(int d);
    int e = d & 16'hFFFE;
    if (e == 0) e = 32768;
    return e / 2;
  endfunction

  task automatic restart(int d, int fe, int re, int tmo);
    @(negedge clk);
    enable = 1'b0; hold = 1'b0;
    divider = 16'(d); fall_dly = 16'(fe); rise_dly = 16'(re); tmo_cycles = 16'(tmo);
    @(negedge clk);
    enable = 1'b1;
  endtask

  // One period with S stretched cycles, then the following low phase (R2 R4 R5 R6 R7)
  task automatic run_period(int d, int fe, int re, int s, int tmo);
    int h = half_of(d);
    int fe_e = (fe >= h) ? h - 1 : fe;
    int re_e = (re >= h) ? h - 1 : re;
    int p1 = 2 * h + s;
    restart(d, fe, re, tmo);
    for (int t = 0; t < p1 + h; t++) begin
      logic [3:0] e;
      @(negedge clk);
      hold = (t < h + s);
      #1;
      if (t < h)            e = {1'b1, t == fe_e, 1'b0, 1'b0};
      else if (t < h + s)   e = 4'b0000;
      else if (t < p1)      e = {1'b0, 1'b0, t == h + s + re_e, 1'b0};
      else                  e = {1'b1, (t - p1) == fe_e, 1'b0, 1'b0};
      chk((s > 0) ? "R7" : ((fe >= h || re >= h) ? "R6" : "R2 R4 R5"), t, obs(), e);
    end
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", -1, obs(), 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", -1, obs(), 4'b0000);

    // R10: low phase begins right after enable
    restart(8, 0, 0, 0);
    @(negedge clk); #1;
    chk("R10", 0, obs(), 4'b1100);

    // Sweep of dividers (odd ones included) and delays up to past the half point
    for (int d = 2; d <= 13; d++)
      for (int fe = 0; fe <= half_of(d) + 1; fe++)
        for (int re = 0; re <= half_of(d) + 1; re++)
          run_period(d, fe, re, 0, 0);

    // R7 stretching
    for (int s = 1; s <= 7; s += 2) begin
      run_period(8, 1, 2, s, 0);
      run_period(9, 3, 0, s, 3);
    end
    // R8 boundary: one cycle short of tmo*D stretched cycles, no flag
    run_period(8, 0, 1, 15, 2);

    // R8 timeout after tmo*D = 16 stretched cycles, sticky, released
    restart(8, 0, 0, 2);
    for (int t = 0; t < 60; t++) begin
      @(negedge clk); hold = 1'b1; #1;
      chk("R8", t, obs(), {t < 4, t == 0, 1'b0, t >= 20});
    end
    hold = 1'b0;
    @(negedge clk); #1;
    chk("R8", 60, obs(), 4'b0001);
    enable = 1'b0;
    @(negedge clk); #1;
    chk("R1", 61, obs(), 4'b0000);

    // R9 timeout disabled
    restart(4, 0, 0, 0);
    for (int t = 0; t < 300; t++) begin
      @(negedge clk); hold = 1'b1; #1;
      if (t == 299) chk("R9", t, obs(), 4'b0000);
      else if (timeout_flag) chk("R9", t, obs(), 4'b0000);
    end
    hold = 1'b0;

    // R1 enable dropped mid low phase
    restart(20, 3, 3, 0);
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk); #1;
    chk("R1", 4, obs(), 4'b0000);

    // R3 zero-valued divider (0 and 1) gives half period 16384
    for (int d = 0; d <= 1; d++) begin
      restart(d, 0, 0, 0);
      for (int t = 0; t <= 16384; t++) begin
        @(negedge clk); #1;
        if (t == 0)          chk("R3", t, obs(), 4'b1100);
        else if (t == 16383) chk("R3", t, obs(), 4'b1000);
        else if (t == 16384) chk("R3", t, obs(), 4'b0010);
      end
    end

    @(negedge clk);
    enable = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule